// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block drives the clock and data lines of a two-wire open-drain bus one primitive at a time. Five primitives are available: START, repeated START, STOP, write one bit and read one bit. A byte-level controller above it issues them. Each line is modelled as an active-high pull-down enable (`*_oe`) and an input that samples the wired level. Both inputs pass through a two-flop synchronizer before the engine looks at them. The engine never drives a line high. To produce a high level it releases the line, then waits for the wire to follow.

All timing is built from one delay unit H. H is taken from `half_period` in clock cycles, with a floor of 3 so that the synchronizer always settles before the engine looks at the line. Each primitive runs as a fixed list of steps: drive a line, release a line, wait one unit, wait for the clock line to read high, check the data line, sample the data line. A slave that holds the clock low stretches the primitive one unit per failed poll, up to a programmable poll limit. The engine checks for lost arbitration only at the points where it has released the data line: before START, after the STOP edge, and on a written 1. When a check fails or the clock poll limit runs out, the engine releases both lines and ends the primitive with a failure.

Commands enter through a valid/ready handshake. `cmd_ready` is high exactly while the engine is idle, and a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. The engine applies back-pressure for the whole run of a primitive, so a request presented while it is busy is not taken. A requester that drops `cmd_valid` before the engine becomes idle loses that request. Results come back as a one-cycle `done` pulse, with `op_fail` and `rd_bit` valid in that same cycle. Two error flags stay set until `err_clr` is asserted.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both pull-down enables are low, `cmd_ready` is high, and `done`, `op_fail`, `err_arb` and `err_tmo` are low.
- R2: START (cmd_op 0) checks that data reads high, pulls data low, waits H, pulls clock low and waits H. `done` is high 4+2H cycles after the accepting edge, both enables are then high, and the bus shows data falling while the clock is high.
- R3: WRITE (cmd_op 3, bit on `cmd_bit`) drives the bit on data before the clock is released. The bus sees that bit at the rising clock. `done` comes 5+4H cycles after acceptance, with the clock enable high and the data enable equal to the inverse of the bit.
- R4: READ (cmd_op 4) releases data, raises the clock and samples data. `done` comes 5+4H cycles after acceptance, with `rd_bit` equal to the level the slave presented and the data enable low.
- R5: RESTART (cmd_op 1) releases data, raises the clock, then performs a START. `done` comes 6+5H cycles after acceptance, and the bus shows a start condition.
- R6: STOP (cmd_op 2) pulls data low, raises the clock, then releases data. `done` comes 5+4H cycles after acceptance with both enables low, and the bus shows data rising while the clock is high.
- R7: If data reads low at an arbitration check, the primitive fails and `err_arb` sets. The failure `done` lands 1 cycle after acceptance for START, 4+4H for STOP and 3+3H for a written 1. Both enables go low. A written 0 with data held low completes normally.
- R8: The clock-high wait polls once per H. With `stretch_limit` L nonzero, the L-th failed poll fails the primitive, sets `err_tmo` and releases both lines: done at 2+(2+L)H for WRITE. With L = 0 the wait never times out, and each failed poll adds exactly H cycles.
- R9: `err_arb` and `err_tmo` hold until `err_clr` is high at a clock edge. A new error on the same edge as `err_clr` leaves the flag set.
- R10: `cmd_ready` is low from the accepting edge until `done`. `done` is a one-cycle pulse. A `cmd_valid` that rises and drops while the engine is busy is never executed.
- R11: H equals `half_period` when it is 3 or more, and 3 otherwise.
- R12: The undefined opcodes 5 to 7 complete with `done` 1 cycle after acceptance, with no failure and no change on either line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | HALF_W | Delay unit in cycles (floor 3) |
| stretch_limit | input | LIMIT_W | Failed clock polls allowed; 0 = unlimited |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can transfer |
| cmd_op | input | 3 | 0 START, 1 RESTART, 2 STOP, 3 WRITE, 4 READ |
| cmd_bit | input | 1 | Bit to write |
| done | output | 1 | One-cycle completion pulse |
| op_fail | output | 1 | Primitive ended in error (with done) |
| rd_bit | output | 1 | Sampled bit of the last READ |
| err_arb | output | 1 | Sticky arbitration-lost flag |
| err_tmo | output | 1 | Sticky clock-stretch timeout flag |
| err_clr | input | 1 | Clears both sticky flags |
| scl_in | input | 1 | Wired clock line level |
| sda_in | input | 1 | Wired data line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |

## Verification
Every result has a fixed cycle count after the accepting edge, set by the step list and H: 4+2H, 5+4H or 6+5H for a clean primitive, the R7 and R8 offsets for failures, and 1 for undefined codes. The bench works these numbers out from the requirements and counts edges from acceptance, sampling on the falling edge. On each cycle before the due count it requires `done` and `cmd_ready` low. It requires `done` exactly at the due count, and checks the line enables, flags and bus-monitor captures in that same sampling slot. For stretched reads, where the release time is set by the bench slave, the bench requires the latency to be the clean value plus a whole multiple of H.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  localparam int OP_W   = 3;
  localparam int STEP_W = 4;

  localparam logic [OP_W-1:0] OP_START   = 3'd0;
  localparam logic [OP_W-1:0] OP_RESTART = 3'd1;
  localparam logic [OP_W-1:0] OP_STOP    = 3'd2;
  localparam logic [OP_W-1:0] OP_WRITE   = 3'd3;
  localparam logic [OP_W-1:0] OP_READ    = 3'd4;

  // One micro-step of a primitive.
  typedef enum logic [3:0] {
    U_END,     // finish, pulse done
    U_SDA_LO,  // pull data low
    U_SDA_HI,  // release data
    U_SDA_BIT, // drive data from the write bit
    U_SCL_LO,  // pull clock low
    U_SCL_HI,  // release clock
    U_DLY,     // wait one delay unit
    U_WSCL,    // wait one unit, then poll clock high
    U_CHK,     // data must read high
    U_CHKBIT,  // data must read high when writing a 1
    U_SMP      // capture data
  } uop_e;

  // Step list of each primitive.
  function automatic uop_e uop_at(logic [OP_W-1:0] op, logic [STEP_W-1:0] idx);
    uop_e u;
    u = U_END;
    case (op)
      OP_START: case (idx)
        4'd0: u = U_CHK;    4'd1: u = U_SDA_LO; 4'd2: u = U_DLY;
        4'd3: u = U_SCL_LO; 4'd4: u = U_DLY;    default: u = U_END;
      endcase
      OP_RESTART: case (idx)
        4'd0: u = U_SDA_HI; 4'd1: u = U_DLY;    4'd2: u = U_SCL_HI;
        4'd3: u = U_WSCL;   4'd4: u = U_DLY;    4'd5: u = U_CHK;
        4'd6: u = U_SDA_LO; 4'd7: u = U_DLY;    4'd8: u = U_SCL_LO;
        4'd9: u = U_DLY;    default: u = U_END;
      endcase
      OP_STOP: case (idx)
        4'd0: u = U_SDA_LO; 4'd1: u = U_DLY;    4'd2: u = U_SCL_HI;
        4'd3: u = U_WSCL;   4'd4: u = U_DLY;    4'd5: u = U_SDA_HI;
        4'd6: u = U_DLY;    4'd7: u = U_CHK;    default: u = U_END;
      endcase
      OP_WRITE: case (idx)
        4'd0: u = U_SDA_BIT; 4'd1: u = U_DLY;   4'd2: u = U_SCL_HI;
        4'd3: u = U_DLY;     4'd4: u = U_WSCL;  4'd5: u = U_CHKBIT;
        4'd6: u = U_SCL_LO;  4'd7: u = U_DLY;   default: u = U_END;
      endcase
      OP_READ: case (idx)
        4'd0: u = U_SDA_HI; 4'd1: u = U_DLY;    4'd2: u = U_SCL_HI;
        4'd3: u = U_WSCL;   4'd4: u = U_DLY;    4'd5: u = U_SMP;
        4'd6: u = U_SCL_LO; 4'd7: u = U_DLY;    default: u = U_END;
      endcase
      default: u = U_END;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  // Idle bus reads high, so the chain resets to ones.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int HALF_W   = 16,
  parameter int MIN_HALF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_period,
  input  logic              run,
  output logic              tick
);
  localparam logic [HALF_W-1:0] FLOOR = HALF_W'(MIN_HALF);

  logic [HALF_W-1:0] eff;
  logic [HALF_W-1:0] cnt;

  assign eff  = (half_period < FLOOR) ? FLOOR : half_period;
  assign tick = run && (cnt == eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R11: the counter never passes the floored delay unit
  p_tick_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < eff));
endmodule

// File: rtl/i2c_stretch_guard.sv
module i2c_stretch_guard #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               poll_fail,
  input  logic               clear,
  output logic               hit
);
  logic [LIMIT_W-1:0] fails;
  logic [LIMIT_W:0]   next_cnt;

  assign next_cnt = {1'b0, fails} + 1'b1;
  assign hit = poll_fail && (limit != '0) && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                clear_blk: fails <= '0;
    else if (clear)            fails <= '0;
    else if (poll_fail && !hit) fails <= next_cnt[LIMIT_W-1:0];
  end

  // R8: failed polls stay below a nonzero limit
  p_fail_below_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) && $stable(limit) |=> (fails < limit) || $changed(limit));
endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_bit_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            cmd_bit,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            tick,
  input  logic            guard_hit,
  output logic            cmd_ready,
  output logic            timer_run,
  output logic            poll_fail,
  output logic            poll_clear,
  output logic            arb_evt,
  output logic            tmo_evt,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            done,
  output logic            op_fail,
  output logic            rd_bit
);
  logic              busy;
  logic [OP_W-1:0]   op_q;
  logic              bit_q;
  logic [STEP_W-1:0] step;
  uop_e              uop;
  logic              abort;

  assign uop       = busy ? uop_at(op_q, step) : U_END;
  assign cmd_ready = !busy;
  assign timer_run = busy && (uop == U_DLY || uop == U_WSCL);
  assign poll_fail = busy && (uop == U_WSCL) && tick && !scl_s;
  assign poll_clear = !busy || ((uop == U_WSCL) && tick && scl_s);
  assign arb_evt   = busy && !sda_s &&
                     ((uop == U_CHK) || (uop == U_CHKBIT && bit_q));
  assign tmo_evt   = poll_fail && guard_hit;
  assign abort     = arb_evt || tmo_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_q    <= '0;
      bit_q   <= 1'b0;
      step    <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      done    <= 1'b0;
      op_fail <= 1'b0;
      rd_bit  <= 1'b0;
    end else begin
      done    <= 1'b0;
      op_fail <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy  <= 1'b1;
          op_q  <= cmd_op;
          bit_q <= cmd_bit;
          step  <= '0;
        end
      end else if (abort) begin
        busy    <= 1'b0;
        scl_oe  <= 1'b0;
        sda_oe  <= 1'b0;
        done    <= 1'b1;
        op_fail <= 1'b1;
      end else begin
        case (uop)
          U_END: begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          U_SDA_LO:  begin sda_oe <= 1'b1;   step <= step + 1'b1; end
          U_SDA_HI:  begin sda_oe <= 1'b0;   step <= step + 1'b1; end
          U_SDA_BIT: begin sda_oe <= !bit_q; step <= step + 1'b1; end
          U_SCL_LO:  begin scl_oe <= 1'b1;   step <= step + 1'b1; end
          U_SCL_HI:  begin scl_oe <= 1'b0;   step <= step + 1'b1; end
          U_DLY:     if (tick) step <= step + 1'b1;
          U_WSCL:    if (tick && scl_s) step <= step + 1'b1;
          U_CHK, U_CHKBIT: step <= step + 1'b1;
          U_SMP:     begin rd_bit <= sda_s; step <= step + 1'b1; end
          default:   step <= step + 1'b1;
        endcase
      end
    end
  end

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: an accepted command blocks the next one
  p_accept_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R7: a failing primitive leaves both lines released
  p_fail_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_fail |-> (!scl_oe && !sda_oe && done));
  // R10: completion always returns the engine to idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_arb,
  input  logic set_tmo,
  input  logic clr,
  output logic err_arb,
  output logic err_tmo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_arb <= 1'b0;
      err_tmo <= 1'b0;
    end else begin
      if (set_arb)  err_arb <= 1'b1;
      else if (clr) err_arb <= 1'b0;
      if (set_tmo)  err_tmo <= 1'b1;
      else if (clr) err_tmo <= 1'b0;
    end
  end

  // R9: flags hold until cleared
  p_sticky_arb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_arb && !clr) |=> err_arb);
  p_sticky_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_tmo && !clr) |=> err_tmo);
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int LIMIT_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HALF    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HALF_W-1:0]  half_period,
  input  logic [LIMIT_W-1:0] stretch_limit,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [OP_W-1:0]    cmd_op,
  input  logic               cmd_bit,
  output logic               done,
  output logic               op_fail,
  output logic               rd_bit,
  output logic               err_arb,
  output logic               err_tmo,
  input  logic               err_clr,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               scl_oe,
  output logic               sda_oe
);
  logic [1:0] line_s;
  logic tick, timer_run, poll_fail, poll_clear, guard_hit, arb_evt, tmo_evt;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s));

  i2c_half_timer #(.HALF_W(HALF_W), .MIN_HALF(MIN_HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .run(timer_run), .tick(tick));

  i2c_stretch_guard #(.LIMIT_W(LIMIT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .limit(stretch_limit),
    .poll_fail(poll_fail), .clear(poll_clear), .hit(guard_hit));

  i2c_bit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .scl_s(line_s[1]), .sda_s(line_s[0]), .tick(tick),
    .guard_hit(guard_hit), .cmd_ready(cmd_ready), .timer_run(timer_run),
    .poll_fail(poll_fail), .poll_clear(poll_clear), .arb_evt(arb_evt),
    .tmo_evt(tmo_evt), .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done),
    .op_fail(op_fail), .rd_bit(rd_bit));

  i2c_err_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_arb(arb_evt), .set_tmo(tmo_evt),
    .clr(err_clr), .err_arb(err_arb), .err_tmo(err_tmo));

  // R8: a timeout is only ever reported together with a failing done
  p_tmo_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_tmo) |-> (done && op_fail));
endmodule

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half_period = 16'd4;
  logic [15:0] stretch_limit = 16'd0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_bit = 1'b0;
  logic        err_clr = 1'b0;
  logic        cmd_ready, done, op_fail, rd_bit, err_arb, err_tmo, scl_oe, sda_oe;
  logic        scl_hold = 1'b0, sda_hold = 1'b0;
  logic        scl_line, sda_line;

  int checks = 0, errors = 0;
  int starts = 0, stops = 0;
  logic cap_bit = 1'b0;

  always #4 clk = ~clk;

  assign scl_line = !(scl_oe || scl_hold);
  assign sda_line = !(sda_oe || sda_hold);

  i2c_bit_engine dut_i (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .stretch_limit(stretch_limit), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .done(done), .op_fail(op_fail),
    .rd_bit(rd_bit), .err_arb(err_arb), .err_tmo(err_tmo), .err_clr(err_clr),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // Bus monitor: conditions and the bit seen at each rising clock.
  always @(negedge sda_line) if (scl_line) starts++;
  always @(posedge sda_line) if (scl_line) stops++;
  always @(posedge scl_line) cap_bit = sda_line;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one command; exp_n < 0 means the latency is not fixed in advance.
  task automatic run_cmd(input logic [2:0] op, input logic b, input int exp_n,
                         input bit exp_fail, input string req, output int kd);
    bit early;
    early = 1'b0;
    kd = -1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    @(negedge clk);                 // after the accepting edge
    cmd_valid = 1'b0;
    for (int k = 1; k < 3000; k++) begin
      @(negedge clk);
      if (done) begin kd = k; break; end
      if (cmd_ready) early = 1'b1;  // reference: engine busy until done
    end
    chk(!early, req, 1, 0);
    if (exp_n >= 0) chk(kd == exp_n, req, kd, exp_n);
    chk(op_fail == exp_fail, req, op_fail, exp_fail);
    chk(cmd_ready == 1'b1, req, cmd_ready, 1);
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int kd, s0, p0, dn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1", {scl_oe, sda_oe}, 0);
    chk(cmd_ready && !done && !op_fail, "R1", cmd_ready, 1);
    chk(!err_arb && !err_tmo, "R1", {err_arb, err_tmo}, 0);

    // R2 START, H=4
    s0 = starts;
    run_cmd(3'd0, 1'b0, 12, 1'b0, "R2", kd);
    chk(scl_oe && sda_oe, "R2", {scl_oe, sda_oe}, 3);
    chk(starts == s0 + 1, "R2", starts - s0, 1);

    // R3 WRITE 1 and 0
    run_cmd(3'd3, 1'b1, 21, 1'b0, "R3", kd);
    chk(cap_bit == 1'b1, "R3", cap_bit, 1);
    chk(scl_oe && !sda_oe, "R3", {scl_oe, sda_oe}, 2);
    run_cmd(3'd3, 1'b0, 21, 1'b0, "R3", kd);
    chk(cap_bit == 1'b0, "R3", cap_bit, 0);
    chk(scl_oe && sda_oe, "R3", {scl_oe, sda_oe}, 3);

    // R4 READ: slave presents 1, then 0
    run_cmd(3'd4, 1'b0, 21, 1'b0, "R4", kd);
    chk(rd_bit == 1'b1, "R4", rd_bit, 1);
    sda_hold = 1'b1;
    run_cmd(3'd4, 1'b0, 21, 1'b0, "R4", kd);
    chk(rd_bit == 1'b0, "R4", rd_bit, 0);
    chk(scl_oe && !sda_oe, "R4", {scl_oe, sda_oe}, 2);
    sda_hold = 1'b0;

    // R5 RESTART
    s0 = starts;
    run_cmd(3'd1, 1'b0, 26, 1'b0, "R5", kd);
    chk(starts == s0 + 1, "R5", starts - s0, 1);
    chk(scl_oe && sda_oe, "R5", {scl_oe, sda_oe}, 3);

    // R6 STOP
    p0 = stops;
    run_cmd(3'd2, 1'b0, 21, 1'b0, "R6", kd);
    chk(stops == p0 + 1, "R6", stops - p0, 1);
    chk(!scl_oe && !sda_oe, "R6", {scl_oe, sda_oe}, 0);

    // R12 undefined opcode
    run_cmd(3'd7, 1'b0, 1, 1'b0, "R12", kd);
    chk(!scl_oe && !sda_oe, "R12", {scl_oe, sda_oe}, 0);

    // R7 arbitration lost before START
    sda_hold = 1'b1;
    run_cmd(3'd0, 1'b0, 1, 1'b1, "R7", kd);
    chk(err_arb && !scl_oe && !sda_oe, "R7", err_arb, 1);
    sda_hold = 1'b0;
    clear_flags();
    chk(!err_arb, "R9", err_arb, 0);

    // R9 a new error beats a simultaneous clear
    sda_hold = 1'b1;
    err_clr = 1'b1;
    run_cmd(3'd0, 1'b0, 1, 1'b1, "R9", kd);
    err_clr = 1'b0;
    @(negedge clk);
    chk(err_arb, "R9", err_arb, 1);
    sda_hold = 1'b0;
    clear_flags();

    // R7 arbitration lost after STOP
    run_cmd(3'd0, 1'b0, 12, 1'b0, "R7", kd);
    sda_hold = 1'b1;
    run_cmd(3'd2, 1'b0, 20, 1'b1, "R7", kd);
    chk(err_arb, "R7", err_arb, 1);
    sda_hold = 1'b0;
    clear_flags();

    // R7 written 0 ignores a low data line; written 1 loses
    run_cmd(3'd0, 1'b0, 12, 1'b0, "R7", kd);
    sda_hold = 1'b1;
    run_cmd(3'd3, 1'b0, 21, 1'b0, "R7", kd);
    chk(!err_arb, "R7", err_arb, 0);
    run_cmd(3'd3, 1'b1, 15, 1'b1, "R7", kd);
    chk(err_arb && !scl_oe && !sda_oe, "R7", err_arb, 1);
    sda_hold = 1'b0;
    clear_flags();

    // R8 timeout after 3 failed polls
    stretch_limit = 16'd3;
    run_cmd(3'd0, 1'b0, 12, 1'b0, "R8", kd);
    scl_hold = 1'b1;
    run_cmd(3'd3, 1'b0, 22, 1'b1, "R8", kd);
    chk(err_tmo && !err_arb, "R8", err_tmo, 1);
    chk(!scl_oe && !sda_oe, "R8", {scl_oe, sda_oe}, 0);
    scl_hold = 1'b0;
    clear_flags();
    chk(!err_tmo, "R9", err_tmo, 0);

    // R8 unlimited stretch, released later by the slave
    stretch_limit = 16'd0;
    run_cmd(3'd0, 1'b0, 12, 1'b0, "R8", kd);
    scl_hold = 1'b1;
    fork
      run_cmd(3'd4, 1'b0, -1, 1'b0, "R8", kd);
      begin repeat (40) @(negedge clk); scl_hold = 1'b0; end
    join
    chk(kd > 21 && ((kd - 21) % 4) == 0, "R8", kd, 21);
    chk(!err_tmo, "R8", err_tmo, 0);

    // R10 a short request while busy is not executed
    run_cmd(3'd2, 1'b0, 21, 1'b0, "R10", kd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    dn = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) dn++;
    end
    chk(dn == 1, "R10", dn, 1);
    chk(scl_oe && sda_oe, "R10", {scl_oe, sda_oe}, 3);

    // R11 floor of the delay unit (half_period 1 -> H 3)
    half_period = 16'd1;
    run_cmd(3'd2, 1'b0, 17, 1'b0, "R11", kd);
    run_cmd(3'd0, 1'b0, 10, 1'b0, "R11", kd);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule